// File: doc/BRIEF.md
# PWM Counter Compare Trigger Unit

This block watches the running counter of the reference PWM channel and compares it against a value that software programs. When the counter reaches that value, and the counting direction is one the block has been told to accept, it produces a hit. A single hit can do several things at once: set a sticky flag that drives an interrupt, send a one-cycle pulse on either or both of two separate event lines (for example to start ADC conversions), and raise a DMA request that stays up until it is acknowledged. The waveform generator that owns the counter is not part of this block.

Software reaches the unit through a small register port with three addresses. The compare value is written into a shadow register. It moves into the active comparator only in a cycle where the counter is zero, which is the start of the period, so a new value never cuts a period short. A hit is counted once, on the first cycle in which the counter equals the active value. A counter that stalls on the matching value gives no further hits.

Top module: `pwm_cmp_trig`

## Requirements
- R1: After reset, irq, ev0, ev1, dmaReq and rdData are 0, the control register (address 0) reads 0, and the compare value (address 1) reads all ones.
- R2: A hit occurs in the first cycle in which cnt equals the active compare value and the direction qualifier passes. No further hit occurs while that condition stays true.
- R3: The direction select is in control bits [5:4]. A value of 0 accepts only up-counting (cntDown=0), 1 accepts only down-counting (cntDown=1), and 2 or 3 accept both.
- R4: When control bit 1 is set, ev0 goes high for exactly one cycle, on the clock edge that ends the hit cycle.
- R5: When control bit 2 is set, ev1 pulses in the same way as ev0, and independently of it.
- R6: Every hit sets a sticky status flag, whether or not the interrupt is enabled. irq equals that flag ANDed with control bit 0.
- R7: A read of address 2 returns the flag in bit 0 and clears the flag. If a hit happens on the same edge as the read, the flag stays set and the read returns the old value.
- R8: A write to address 1 loads the shadow value, which reads back at address 1. The active compare value takes the shadow value only on an edge where cnt is 0.
- R9: When control bit 3 is set, a hit sets dmaReq. dmaReq stays high until dmaAck is sampled high. If a hit and dmaAck occur on the same edge, dmaReq stays set.
- R10: A write to address 0 stores control bits [5:0], which read back at address 0. Read data appears on the edge that samples rdEn and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | CNT_W | Counter of the reference channel |
| cntDown | input | 1 | 1 while that counter counts down |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | CNT_W | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 2 | Read address |
| rdData | output | CNT_W | Registered read data |
| dmaAck | input | 1 | DMA acknowledge |
| irq | output | 1 | Interrupt |
| ev0 | output | 1 | Event line 0 pulse |
| ev1 | output | 1 | Event line 1 pulse |
| dmaReq | output | 1 | DMA request |

## Verification
The bench builds the unit with CNT_W set to 8. At that width the whole compare range fits in one byte, so the vectors can put hits at the bottom of the range, in the middle, and at the all-ones top of the range, which is also the reset compare value. The narrow width also lets the bench write the compare value by hand. The directed tests cover the cases where two rules meet on one edge: a hit together with a status read, a hit together with a DMA acknowledge, and a shadow write that must not take effect before the counter passes zero.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic [1:0] dirSel;
    logic       dmaEn;
    logic       ev1En;
    logic       ev0En;
    logic       irqEn;
  } cfg_t;

  typedef struct packed {
    logic wrCtrl;
    logic wrCmp;
    logic rdStat;
    logic rdReq;
  } strobe_t;
endpackage

// File: rtl/pwm_cmp_datapath.sv
module pwm_cmp_datapath
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cntDown,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  input  logic             statFlag,
  output cfg_t             cfg,
  output logic             hit,
  output logic [CNT_W-1:0] rdData
);
  localparam int CFG_W = $bits(cfg_t);

  logic [CNT_W-1:0] shadowCmp;
  logic [CNT_W-1:0] activeCmp;
  logic             eqPrev;
  logic             eqNow;
  logic             dirOk;
  logic [CNT_W-1:0] rdMux;

  always_comb begin
    dirOk = cfg.dirSel[1] | (cfg.dirSel[0] == cntDown);
    eqNow = (cnt == activeCmp) && dirOk;
    hit   = eqNow && !eqPrev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      shadowCmp <= '1;
      activeCmp <= '1;
      eqPrev    <= 1'b0;
    end else begin
      eqPrev <= eqNow;
      if (stb.wrCtrl) cfg <= cfg_t'(wrData[CFG_W-1:0]);
      if (stb.wrCmp)  shadowCmp <= wrData;
      if (cnt == '0)  activeCmp <= shadowCmp;
    end
  end

  always_comb begin
    rdMux = '0;
    case (rdAddr)
      ADDR_CTRL: rdMux[CFG_W-1:0] = cfg;
      ADDR_CMP:  rdMux = shadowCmp;
      ADDR_STAT: rdMux[0] = statFlag;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdData <= '0;
    else if (stb.rdReq) rdData <= rdMux;
  end

  // R8: the active value only moves on a zero count
  a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(activeCmp));
  // R2: no back-to-back hits
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/pwm_cmp_ctrl.sv
module pwm_cmp_ctrl
  import pwm_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       rdEn,
  input  logic [1:0] rdAddr,
  input  logic       dmaAck,
  input  cfg_t       cfg,
  input  logic       hit,
  output strobe_t    stb,
  output logic       statFlag,
  output logic       irq,
  output logic       ev0,
  output logic       ev1,
  output logic       dmaReq
);
  always_comb begin
    stb.wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
    stb.wrCmp  = wrEn && (wrAddr == ADDR_CMP);
    stb.rdStat = rdEn && (rdAddr == ADDR_STAT);
    stb.rdReq  = rdEn;
    irq        = statFlag && cfg.irqEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statFlag <= 1'b0;
      ev0      <= 1'b0;
      ev1      <= 1'b0;
      dmaReq   <= 1'b0;
    end else begin
      ev0 <= hit && cfg.ev0En;
      ev1 <= hit && cfg.ev1En;
      if (hit)             statFlag <= 1'b1;
      else if (stb.rdStat) statFlag <= 1'b0;
      if (hit && cfg.dmaEn) dmaReq <= 1'b1;
      else if (dmaAck)      dmaReq <= 1'b0;
    end
  end

  // R4: event pulse is one cycle wide
  a_r4_ev0_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev0 |=> !ev0);
  // R5: same for line 1
  a_r5_ev1_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev1 |=> !ev1);
  // R6: flag survives until a status read
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (statFlag && !stb.rdStat) |=> statFlag);
  // R9: request held until acknowledged
  a_r9_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaReq && !dmaAck) |=> dmaReq);
  // R4: a pulse always follows a hit
  a_r4_ev_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev0) |-> $past(hit));
endmodule

// File: rtl/pwm_cmp_trig.sv
module pwm_cmp_trig
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cntDown,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdEn,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             dmaAck,
  output logic             irq,
  output logic             ev0,
  output logic             ev1,
  output logic             dmaReq
);
  strobe_t stb;
  cfg_t    cfg;
  logic    hit;
  logic    statFlag;

  pwm_cmp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cntDown(cntDown), .stb(stb),
    .wrData(wrData), .rdAddr(rdAddr), .statFlag(statFlag), .cfg(cfg),
    .hit(hit), .rdData(rdData)
  );

  pwm_cmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn),
    .rdAddr(rdAddr), .dmaAck(dmaAck), .cfg(cfg), .hit(hit), .stb(stb),
    .statFlag(statFlag), .irq(irq), .ev0(ev0), .ev1(ev1), .dmaReq(dmaReq)
  );
endmodule

// File: tb/pwm_cmp_trig_bench.sv
module pwm_cmp_trig_bench;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic cntDown = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [1:0] rdAddr = '0;
  logic [W-1:0] rdData;
  logic dmaAck = 1'b0;
  logic irq, ev0, ev1, dmaReq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_cmp_trig #(.CNT_W(W)) u_pwm_cmp_trig (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cntDown(cntDown), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .dmaAck(dmaAck), .irq(irq), .ev0(ev0), .ev1(ev1),
    .dmaReq(dmaReq)
  );

  // {ctrl[7:0], cmp[7:0], cnt[7:0], down, expectHit}
  localparam int NV = 8;
  localparam logic [25:0] VEC [0:NV-1] = '{
    {8'h0F, 8'd40,  8'd40,  1'b0, 1'b1},
    {8'h1F, 8'd40,  8'd40,  1'b0, 1'b0},
    {8'h1F, 8'd77,  8'd77,  1'b1, 1'b1},
    {8'h23, 8'd5,   8'd5,   1'b1, 1'b1},
    {8'h04, 8'd200, 8'd199, 1'b0, 1'b0},
    {8'h04, 8'd200, 8'd200, 1'b0, 1'b1},
    {8'h38, 8'd255, 8'd255, 1'b1, 1'b1},
    {8'h0E, 8'd9,   8'd9,   1'b0, 1'b1}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [1:0] a, input logic [W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d; step(); wrEn = 1'b0;
  endtask

  task automatic regRd(input logic [1:0] a, output logic [W-1:0] d);
    rdEn = 1'b1; rdAddr = a; step(); d = rdData; rdEn = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    cnt = 8'd3;
    step(); step();
    rst_n = 1'b1; #1;
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 ev0", ev0, 0); chk("R1 ev1", ev1, 0);
    chk("R1 dmaReq", dmaReq, 0); chk("R1 rdData", rdData, 0);
    regRd(2'd0, r); chk("R1 ctrl", r, 0);
    regRd(2'd1, r); chk("R1 cmp", r, 255);

    // Table walk: R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [7:0] c;
      logic [7:0] cv;
      logic [7:0] nv;
      logic dn;
      logic h;
      {c, cv, nv, dn, h} = VEC[i];
      cnt = '0; cntDown = 1'b0; step();
      regWr(2'd0, c);
      regWr(2'd1, cv);
      regRd(2'd0, r); chk("R10 ctrl readback", r, c[5:0]);
      step();                      // cnt==0 loads active
      cnt = nv; cntDown = dn; step();
      chk("R4 ev0", ev0, h & c[1]);
      chk("R5 ev1", ev1, h & c[2]);
      chk("R9 dmaReq", dmaReq, h & c[3]);
      chk("R6 irq", irq, h & c[0]);
      step();
      chk("R2 no repeat ev0", ev0, 0);
      chk("R2 no repeat ev1", ev1, 0);
      chk("R9 dma held", dmaReq, h & c[3]);
      dmaAck = 1'b1; step(); dmaAck = 1'b0;
      chk("R9 dma ack", dmaReq, 0);
      regRd(2'd2, r); chk("R3 R7 status", r[0], h);
      regRd(2'd2, r); chk("R7 cleared", r[0], 0);
    end

    // R8 shadow vs active
    cnt = '0; step();
    regWr(2'd0, 8'h03);
    regWr(2'd1, 8'd60); step();
    cnt = 8'd30; step();
    regWr(2'd1, 8'd50);
    regRd(2'd1, r); chk("R8 shadow readback", r, 50);
    cnt = 8'd50; step();
    chk("R8 no early load", ev0, 0);
    cnt = '0; step(); step();
    cnt = 8'd50; step();
    chk("R8 loaded at zero", ev0, 1);

    // R7 hit on the same edge as a status read
    cnt = '0; step();
    regRd(2'd2, r);
    cnt = 8'd50; rdEn = 1'b1; rdAddr = 2'd2; step(); rdEn = 1'b0;
    chk("R7 old value", rdData[0], 0);
    regRd(2'd2, r); chk("R7 set wins", r[0], 1);

    // R9 hit on the same edge as an ack
    cnt = '0; step();
    regWr(2'd0, 8'h08);
    cnt = 8'd50; dmaAck = 1'b1; step(); dmaAck = 1'b0;
    chk("R9 set wins", dmaReq, 1);
    chk("R6 irq disabled", irq, 0);
    regRd(2'd2, r); chk("R6 flag set", r[0], 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule